// File: doc/BRIEF.md
# Mixed Edge/Level Interrupt Source Controller

This block keeps the per-source state that decides when an interrupt is handed to a downstream presenter. Every source is set up through a configuration port with a destination server, an 8-bit priority and a type bit. The type bit selects edge (message) or level behaviour. The all-ones priority masks the source. The block samples the device interrupt lines. It answers reject, end-of-interrupt and resend commands from the presenter, and issues present requests one at a time. Each request carries the server, the global source number and the priority.

Edge and level sources keep separate bookkeeping. An edge source is presented once per rising edge, and presented again only after a reject followed by a resend, or after an unmask that clears its masked-pending flag. A level source is presented while it is asserted and not already sent. End-of-interrupt clears the sent flag, so a line that is still high is presented again at once.

Global source numbers are the local index plus the parameter `BASE`. Numbers outside `[BASE, BASE+NSRC)` are ignored. When a reject or end-of-interrupt names such a number, the block also raises an error pulse.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset, `pres_valid` and `err_pulse` are 0. Every source is edge type with priority 0xFF and all flags clear, so raising a line presents nothing.
- R2: A source with priority 0xFF is never presented. A rising edge on a masked edge source sets its masked-pending flag.
- R3: An edge source (`cfg_level`=0) that is unmasked presents once for each rising edge of its line. A line held high produces no further presents.
- R4: A level source (`cfg_level`=1) is presented when its priority is not 0xFF, its line is high and its sent flag is clear. Presenting sets sent. This rule is evaluated when the line changes, on a configuration write, on end-of-interrupt and on resend.
- R5: End-of-interrupt (`cmd_op`=2) on a level source clears sent and applies the R4 rule, so a source whose line is still high is presented again. End-of-interrupt on an edge source changes no state.
- R6: Reject (`cmd_op`=1) sets rejected and clears sent for either type. Resend (`cmd_op`=3) visits every source. An edge source with rejected set has rejected cleared and is presented if unmasked. A level source applies the R4 rule. `cmd_op`=0 does nothing.
- R7: A configuration write stores server, priority and type first. An edge source then presents if masked-pending is set and the new priority is not 0xFF, and masked-pending is cleared. A level source then applies the R4 rule.
- R8: `pres_num` equals `BASE` plus the local index. Configuration writes and commands that name a number outside `[BASE, BASE+NSRC)` are ignored.
- R9: A reject or end-of-interrupt that names an invalid number makes `err_pulse` high for exactly the one cycle after the command.
- R10: At most one present is issued per cycle, and the lowest ready index goes first. While `pres_valid` is high and `pres_ready` is low, all present fields hold stable. A source becomes visible on the output two clock edges after its triggering input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NSRC | Device interrupt lines, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_num | input | NUM_W | Global source number to configure |
| cfg_server | input | SRV_W | Destination server |
| cfg_prio | input | PRIO_W | Priority (all ones = masked) |
| cfg_level | input | 1 | Type: 1 level, 0 edge |
| cmd_valid | input | 1 | Presenter command strobe |
| cmd_op | input | 2 | 0 nop, 1 reject, 2 end-of-interrupt, 3 resend |
| cmd_num | input | NUM_W | Global source number for reject or end-of-interrupt |
| pres_valid | output | 1 | Present request valid |
| pres_ready | input | 1 | Presenter accepts the request |
| pres_server | output | SRV_W | Server of the presented source |
| pres_num | output | NUM_W | Global number of the presented source |
| pres_prio | output | PRIO_W | Priority of the presented source |
| err_pulse | output | 1 | One-cycle pulse for an invalid reject or end-of-interrupt |

## Verification
The hardest state to reach is a level source whose present has gone out, whose line is still high, and which then receives a reject, a resend and an end-of-interrupt in the right order. From the ports alone, that state can only be built by sequencing configuration, line and command traffic precisely. The bench drives that sequence directly. It also holds `pres_ready` low while several lines rise in the same cycle, which tests ordering and field stability. A long stretch of random lines, stalls, configuration writes and commands, including out-of-range numbers, then runs against a behavioural model that is compared on every clock.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  typedef enum logic [1:0] {
    OP_NOP    = 2'd0,
    OP_REJECT = 2'd1,
    OP_EOI    = 2'd2,
    OP_RESEND = 2'd3
  } cmd_op_e;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot #(
  parameter int SRV_W  = 4,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_line,
  input  logic              cfg_hit,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              cfg_level,
  input  logic              rej_hit,
  input  logic              eoi_hit,
  input  logic              resend,
  input  logic              grant,
  output logic              ready_o,
  output logic [SRV_W-1:0]  server_o,
  output logic [PRIO_W-1:0] prio_o
);
  localparam logic [PRIO_W-1:0] MASKED = '1;

  logic line_q, level_q, sent_q, rej_q, mpend_q, req_q;
  logic [SRV_W-1:0]  srv_q;
  logic [PRIO_W-1:0] prio_q;

  logic n_level, n_sent, n_rej, n_mpend, n_req;
  logic [SRV_W-1:0]  n_srv;
  logic [PRIO_W-1:0] n_prio;

  function automatic logic lvl_go(input logic [PRIO_W-1:0] p, input logic a, input logic s);
    return (p != MASKED) && a && !s;
  endfunction

  always_comb begin
    n_level = level_q; n_sent = sent_q; n_rej = rej_q;
    n_mpend = mpend_q; n_req = req_q; n_srv = srv_q; n_prio = prio_q;
    if (grant) n_req = 1'b0;
    // line activity
    if (level_q) begin
      if ((irq_line != line_q) && lvl_go(prio_q, irq_line, n_sent)) begin
        n_sent = 1'b1; n_req = 1'b1;
      end
    end else if (irq_line && !line_q) begin
      if (prio_q != MASKED) n_req = 1'b1;
      else n_mpend = 1'b1;
    end
    // configuration
    if (cfg_hit) begin
      n_srv = cfg_server; n_prio = cfg_prio; n_level = cfg_level;
      if (cfg_level) begin
        if (lvl_go(cfg_prio, irq_line, n_sent)) begin
          n_sent = 1'b1; n_req = 1'b1;
        end
      end else if (n_mpend && (cfg_prio != MASKED)) begin
        n_mpend = 1'b0; n_req = 1'b1;
      end
    end
    // presenter commands
    if (rej_hit) begin
      n_rej = 1'b1; n_sent = 1'b0;
    end
    if (eoi_hit && n_level) begin
      n_sent = 1'b0;
      if (lvl_go(n_prio, irq_line, 1'b0)) begin
        n_sent = 1'b1; n_req = 1'b1;
      end
    end
    if (resend) begin
      if (n_level) begin
        if (lvl_go(n_prio, irq_line, n_sent)) begin
          n_sent = 1'b1; n_req = 1'b1;
        end
      end else if (n_rej) begin
        n_rej = 1'b0;
        if (n_prio != MASKED) n_req = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0; level_q <= 1'b0; sent_q <= 1'b0; rej_q <= 1'b0;
      mpend_q <= 1'b0; req_q <= 1'b0; srv_q <= '0; prio_q <= MASKED;
    end else begin
      line_q <= irq_line; level_q <= n_level; sent_q <= n_sent; rej_q <= n_rej;
      mpend_q <= n_mpend; req_q <= n_req; srv_q <= n_srv; prio_q <= n_prio;
    end
  end

  assign ready_o  = req_q && (prio_q != MASKED);
  assign server_o = srv_q;
  assign prio_o   = prio_q;

  // R4: a level source only becomes sent while its line is high
  assert_level_sent_R4: assert property (@(posedge clk) disable iff (rst)
    (level_q && $rose(sent_q)) |-> line_q);
  // R6: reject leaves rejected set and sent clear
  assert_reject_flags_R6: assert property (@(posedge clk) disable iff (rst)
    rej_hit |=> (rej_q && !sent_q));
endmodule

// File: rtl/irq_src_arb.sv
module irq_src_arb #(
  parameter int NSRC   = 8,
  parameter int SRV_W  = 4,
  parameter int PRIO_W = 8,
  parameter int NUM_W  = 8,
  parameter int BASE   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NSRC-1:0]          ready_vec,
  input  logic [NSRC*SRV_W-1:0]    srv_flat,
  input  logic [NSRC*PRIO_W-1:0]   prio_flat,
  input  logic                     pres_ready,
  output logic [NSRC-1:0]          grant,
  output logic                     pres_valid,
  output logic [SRV_W-1:0]         pres_server,
  output logic [NUM_W-1:0]         pres_num,
  output logic [PRIO_W-1:0]        pres_prio
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [PRIO_W-1:0] MASKED = '1;

  logic             take, found;
  logic [IDX_W-1:0] pick;

  assign take = !pres_valid || pres_ready;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (ready_vec[i]) begin
        found = 1'b1;
        pick  = IDX_W'(i);
      end
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_grant
    assign grant[g] = take && found && (pick == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pres_valid  <= 1'b0;
      pres_server <= '0;
      pres_num    <= '0;
      pres_prio   <= '0;
    end else if (take) begin
      pres_valid <= found;
      if (found) begin
        pres_server <= srv_flat[pick*SRV_W +: SRV_W];
        pres_prio   <= prio_flat[pick*PRIO_W +: PRIO_W];
        pres_num    <= NUM_W'(BASE) + NUM_W'(pick);
      end
    end
  end

  assert_one_grant_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  assert_hold_fields_R10: assert property (@(posedge clk) disable iff (rst)
    (pres_valid && !pres_ready) |=> (pres_valid && $stable(pres_num)
      && $stable(pres_prio) && $stable(pres_server)));
  assert_never_masked_R2: assert property (@(posedge clk) disable iff (rst)
    pres_valid |-> (pres_prio != MASKED));
  assert_num_range_R8: assert property (@(posedge clk) disable iff (rst)
    pres_valid |-> ((int'(pres_num) >= BASE) && (int'(pres_num) < BASE + NSRC)));
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int SRV_W  = 4,
  parameter int PRIO_W = 8,
  parameter int NUM_W  = 8,
  parameter int BASE   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              cfg_we,
  input  logic [NUM_W-1:0]  cfg_num,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              cfg_level,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [NUM_W-1:0]  cmd_num,
  output logic              pres_valid,
  input  logic              pres_ready,
  output logic [SRV_W-1:0]  pres_server,
  output logic [NUM_W-1:0]  pres_num,
  output logic [PRIO_W-1:0] pres_prio,
  output logic              err_pulse
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  cmd_op_e op;
  assign op = cmd_op_e'(cmd_op);

  logic             cfg_ok, cmd_ok, is_rej, is_eoi, is_resend;
  logic [NUM_W-1:0] cfg_off, cmd_off;
  logic [IDX_W-1:0] cfg_idx, cmd_idx;

  assign cfg_ok    = (int'(cfg_num) >= BASE) && (int'(cfg_num) < BASE + NSRC);
  assign cmd_ok    = (int'(cmd_num) >= BASE) && (int'(cmd_num) < BASE + NSRC);
  assign cfg_off   = cfg_num - NUM_W'(BASE);
  assign cmd_off   = cmd_num - NUM_W'(BASE);
  assign cfg_idx   = cfg_off[IDX_W-1:0];
  assign cmd_idx   = cmd_off[IDX_W-1:0];
  assign is_rej    = cmd_valid && (op == OP_REJECT);
  assign is_eoi    = cmd_valid && (op == OP_EOI);
  assign is_resend = cmd_valid && (op == OP_RESEND);

  logic [NSRC-1:0]        ready_vec, grant;
  logic [NSRC*SRV_W-1:0]  srv_flat;
  logic [NSRC*PRIO_W-1:0] prio_flat;

  for (genvar g = 0; g < NSRC; g++) begin : g_slot
    logic hit_cfg, hit_cmd;
    assign hit_cfg = cfg_we && cfg_ok && (cfg_idx == IDX_W'(g));
    assign hit_cmd = cmd_ok && (cmd_idx == IDX_W'(g));
    irq_src_slot #(.SRV_W(SRV_W), .PRIO_W(PRIO_W)) u_slot (
      .clk(clk), .rst(rst), .irq_line(irq_in[g]),
      .cfg_hit(hit_cfg), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
      .cfg_level(cfg_level),
      .rej_hit(is_rej && hit_cmd), .eoi_hit(is_eoi && hit_cmd),
      .resend(is_resend), .grant(grant[g]),
      .ready_o(ready_vec[g]),
      .server_o(srv_flat[g*SRV_W +: SRV_W]),
      .prio_o(prio_flat[g*PRIO_W +: PRIO_W])
    );
  end

  irq_src_arb #(.NSRC(NSRC), .SRV_W(SRV_W), .PRIO_W(PRIO_W),
                .NUM_W(NUM_W), .BASE(BASE)) u_arb (
    .clk(clk), .rst(rst), .ready_vec(ready_vec), .srv_flat(srv_flat),
    .prio_flat(prio_flat), .pres_ready(pres_ready), .grant(grant),
    .pres_valid(pres_valid), .pres_server(pres_server),
    .pres_num(pres_num), .pres_prio(pres_prio)
  );

  always_ff @(posedge clk) begin
    if (rst) err_pulse <= 1'b0;
    else     err_pulse <= (is_rej || is_eoi) && !cmd_ok;
  end

  // R9: the error pulse never lasts two cycles without a fresh bad command
  assert_err_single_R9: assert property (@(posedge clk) disable iff (rst)
    (err_pulse && !$past(cmd_valid)) |-> 1'b0);
endmodule

// File: tb/irq_src_ctrl_test.sv
`timescale 1ns/1ps
module irq_src_ctrl_test;
  localparam int NSRC = 8, SRV_W = 4, PRIO_W = 8, NUM_W = 8, BASE = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic [NSRC-1:0] irq_in = '0;
  logic cfg_we = 0, cfg_level = 0, cmd_valid = 0, pres_ready = 1;
  logic [NUM_W-1:0] cfg_num = '0, cmd_num = '0;
  logic [SRV_W-1:0] cfg_server = '0;
  logic [PRIO_W-1:0] cfg_prio = '0;
  logic [1:0] cmd_op = '0;
  logic pres_valid, err_pulse;
  logic [SRV_W-1:0] pres_server;
  logic [NUM_W-1:0] pres_num;
  logic [PRIO_W-1:0] pres_prio;

  always #2.5 clk = ~clk;

  irq_src_ctrl #(.NSRC(NSRC), .SRV_W(SRV_W), .PRIO_W(PRIO_W), .NUM_W(NUM_W), .BASE(BASE)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_num(cfg_num),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio), .cfg_level(cfg_level),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_num(cmd_num),
    .pres_valid(pres_valid), .pres_ready(pres_ready), .pres_server(pres_server),
    .pres_num(pres_num), .pres_prio(pres_prio), .err_pulse(err_pulse));

  int checks = 0, errors = 0;
  string phase = "R1";
  bit done = 0;

  // behavioural reference
  int m_srv[NSRC], m_prio[NSRC];
  bit m_lvl[NSRC], m_line[NSRC], m_sent[NSRC], m_rej[NSRC], m_mp[NSRC], m_req[NSRC];
  bit m_v, m_err;
  int m_osrv, m_onum, m_oprio, n_presents;

  task automatic lev(int i);
    if (m_prio[i] != 255 && m_line[i] && !m_sent[i]) begin
      m_sent[i] = 1; m_req[i] = 1;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSRC; i++) begin
        m_srv[i] = 0; m_prio[i] = 255; m_lvl[i] = 0; m_line[i] = 0;
        m_sent[i] = 0; m_rej[i] = 0; m_mp[i] = 0; m_req[i] = 0;
      end
      m_v = 0; m_err = 0;
    end else begin
      int g, ci, mi;
      bit cok, mok;
      g = -1;
      if (!m_v || pres_ready) begin
        for (int i = NSRC - 1; i >= 0; i--)
          if (m_req[i] && m_prio[i] != 255) g = i;
        m_v = (g >= 0);
        if (g >= 0) begin
          m_osrv = m_srv[g]; m_oprio = m_prio[g]; m_onum = BASE + g; n_presents++;
        end
      end
      ci = int'(cfg_num) - BASE; mi = int'(cmd_num) - BASE;
      cok = ci >= 0 && ci < NSRC; mok = mi >= 0 && mi < NSRC;
      m_err = cmd_valid && (cmd_op == 1 || cmd_op == 2) && !mok;
      for (int i = 0; i < NSRC; i++) begin
        if (i == g) m_req[i] = 0;
        if (m_lvl[i]) begin
          if (irq_in[i] != m_line[i]) begin m_line[i] = irq_in[i]; lev(i); end
        end else begin
          if (irq_in[i] && !m_line[i]) begin
            if (m_prio[i] != 255) m_req[i] = 1; else m_mp[i] = 1;
          end
          m_line[i] = irq_in[i];
        end
        if (cfg_we && cok && ci == i) begin
          m_srv[i] = cfg_server; m_prio[i] = cfg_prio; m_lvl[i] = cfg_level;
          if (m_lvl[i]) lev(i);
          else if (m_mp[i] && m_prio[i] != 255) begin m_mp[i] = 0; m_req[i] = 1; end
        end
        if (cmd_valid && mok && mi == i) begin
          if (cmd_op == 1) begin m_rej[i] = 1; m_sent[i] = 0; end
          if (cmd_op == 2 && m_lvl[i]) begin m_sent[i] = 0; lev(i); end
        end
        if (cmd_valid && cmd_op == 3) begin
          if (m_lvl[i]) lev(i);
          else if (m_rej[i]) begin
            m_rej[i] = 0;
            if (m_prio[i] != 255) m_req[i] = 1;
          end
        end
      end
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk(pres_valid == m_v, "pres_valid", pres_valid, m_v);
    if (m_v && pres_valid) begin
      chk(int'(pres_num) == m_onum, "pres_num", pres_num, m_onum);
      chk(int'(pres_prio) == m_oprio, "pres_prio", pres_prio, m_oprio);
      chk(int'(pres_server) == m_osrv, "pres_server", pres_server, m_osrv);
    end
    chk(err_pulse == m_err, "err_pulse", err_pulse, m_err);
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(int num, int srv, int prio, bit lvl);
    cfg_we = 1; cfg_num = NUM_W'(num); cfg_server = SRV_W'(srv);
    cfg_prio = PRIO_W'(prio); cfg_level = lvl;
    tick(); cfg_we = 0;
  endtask

  task automatic cmd(int op, int num);
    cmd_valid = 1; cmd_op = 2'(op); cmd_num = NUM_W'(num);
    tick(); cmd_valid = 0;
  endtask

  task automatic expect_count(int exp, string tag);
    phase = tag;
    chk(n_presents == exp, "present count", n_presents, exp);
  endtask

  initial begin
    n_presents = 0;
    tick(3); rst = 0; tick();
    phase = "R1";
    chk(pres_valid == 0, "reset pres_valid", pres_valid, 0);
    chk(err_pulse == 0, "reset err_pulse", err_pulse, 0);
    irq_in[6] = 1; tick(4); irq_in[6] = 0; tick();
    expect_count(0, "R1");

    phase = "R2"; cfg(BASE, 1, 255, 0);
    irq_in[0] = 1; tick(4); irq_in[0] = 0; tick(2);
    expect_count(0, "R2");
    phase = "R7"; cfg(BASE, 1, 5, 0); tick(3);
    expect_count(1, "R7");

    phase = "R3"; cfg(BASE + 1, 2, 3, 0);
    irq_in[1] = 1; tick(6); irq_in[1] = 0; tick(2);
    expect_count(2, "R3");

    phase = "R4"; cfg(BASE + 2, 3, 4, 1);
    irq_in[2] = 1; tick(6);
    expect_count(3, "R4");
    phase = "R5"; cmd(2, BASE + 2); tick(3);
    expect_count(4, "R5");
    cmd(2, BASE + 1); tick(3);
    expect_count(4, "R5");

    phase = "R6"; cmd(1, BASE + 1); cmd(1, BASE + 2); tick(2);
    cmd(3, 0); tick(3);
    expect_count(6, "R6");
    cmd(0, BASE + 2); tick(2);
    irq_in[2] = 0; tick(2); cmd(2, BASE + 2); tick(2);
    expect_count(6, "R6");

    phase = "R7"; irq_in[7] = 1; tick(2);
    cfg(BASE + 7, 5, 9, 1); tick(3);
    expect_count(7, "R7");
    irq_in[7] = 0; tick();

    phase = "R8"; cfg(BASE + NSRC, 1, 1, 0); cfg(BASE - 1, 1, 1, 0);
    cmd(1, BASE - 1); cmd(3, 0); tick(3);
    expect_count(7, "R8");

    phase = "R9"; cmd(2, BASE + NSRC); tick(); cmd(1, 3); cmd(2, BASE + 3); tick(2);

    phase = "R10"; cfg(BASE + 3, 6, 7, 0); cfg(BASE + 4, 7, 8, 0); cfg(BASE + 5, 8, 2, 0);
    pres_ready = 0; irq_in[5:3] = 3'b111; tick(6);
    pres_ready = 1; tick(5);
    expect_count(10, "R10");
    irq_in = '0; tick(2);

    for (int c = 0; c < 3000; c++) begin
      irq_in = NSRC'($urandom);
      pres_ready = ($urandom % 4) != 0;
      if ($urandom % 6 == 0) begin
        cfg_we = 1; cfg_num = NUM_W'(BASE - 1 + $urandom % (NSRC + 2));
        cfg_server = SRV_W'($urandom); cfg_level = 1'($urandom);
        cfg_prio = ($urandom % 5 == 0) ? 8'hFF : PRIO_W'(1 + $urandom % 4);
      end else cfg_we = 0;
      if ($urandom % 3 == 0) begin
        cmd_valid = 1; cmd_op = 2'($urandom);
        cmd_num = NUM_W'(BASE - 1 + $urandom % (NSRC + 2));
      end else cmd_valid = 0;
      tick();
    end
    cfg_we = 0; cmd_valid = 0; tick(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule